// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (left-justified / I2S)

This block turns a pair of parallel stereo samples into a single serial data line. It does not generate any audio clocks. An external master supplies a bit clock and a frame clock, and the block follows both. The block runs on a faster system clock. It samples the two external clocks through a synchronizer and moves its output one step each time it sees a falling edge of the bit clock. Samples are two's complement and are sent most significant bit first.

A static format input picks one of two framings. In left-justified framing the first bit of a word lines up with the frame-clock edge. In I2S framing the frame polarity is inverted and the whole bit stream is delayed by one bit clock.

The block counts bit clocks over every frame. When the previous frame had exactly 32 of them, the block sends only the upper 16 bits of each sample; otherwise it sends all 24. A host writes the next left/right pair with a load strobe. The pair is taken over as a unit when the next frame begins. A power-down input forces the line low and restarts frame tracking.

Top module: `audio_ser_tx`

## Requirements
- R1: Within a half-frame the slot numbered k, counting from 0 at the half-frame start, carries bit (23-k) of that channel's sample, so the sign bit goes first.
- R2: sdata_o takes its new value on the third rising system-clock edge after a falling bit-clock transition on bclk_i. It does not change at any other time except when power-down forces it low.
- R3: With fmt_i2s_i = 0 the left channel is sent while frame_i is high and the right channel while it is low. Slot 0 of each half begins at the frame_i transition.
- R4: With fmt_i2s_i = 1 the left channel is sent while frame_i is low and the right channel while it is high. The output equals the left-justified stream for that polarity delayed by exactly one bit clock, so a channel's last slot spills into slot 0 of the following half.
- R5: Slots at or beyond the active word length within a half-frame are driven 0.
- R6: If the frame just completed held exactly 32 bit-clock falling edges, the next frame sends words of 16 bits, which are bits 23..8 of the sample. Otherwise the next frame sends 24-bit words. The length is decided again at every frame start.
- R7: left_i/right_i are captured into a pending pair on a cycle where load_i is 1. The pending pair becomes the transmitted pair at the next frame start, so a load in mid-frame changes nothing in the frame already under way.
- R8: While pwr_down_i is 1, sdata_o is 0 from the next system-clock edge on. After release the block waits for a fresh frame start, and that first frame always uses 24-bit words.
- R9: After reset, and after leaving power-down, sdata_o stays 0 until the first frame start is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | External bit clock; the output advances after its falling edges |
| frame_i | input | 1 | External frame (channel select) clock |
| fmt_i2s_i | input | 1 | 0 selects left-justified framing, 1 selects I2S framing |
| pwr_down_i | input | 1 | Power-down; holds the output low and clears frame tracking |
| load_i | input | 1 | Strobe that captures left_i/right_i as the pending pair |
| left_i | input | SAMPLE_W | Left sample, two's complement |
| right_i | input | SAMPLE_W | Right sample, two's complement |
| sdata_o | output | 1 | Serial data output |

## Verification
The assertions assume the following about the inputs:
- Each bit-clock phase lasts several system clocks, so the synchronizer sees every edge.
- frame_i moves only together with a falling bit-clock edge.
- pwr_down_i and load_i are synchronous to clk.
- The format input changes only while power-down is held.

The stimulus keeps to these assumptions. Every bit-clock phase lasts eight system clocks, and the frame level is driven in the same step as the bit-clock fall. Loads are placed in the high phase of the bit clock, well away from a frame start. The format is switched only inside a power-down window, which the bench follows with one idle slot at the right-channel level before the next frame begins.

// File: rtl/audio_ser_tx_pkg.sv
`timescale 1ns/1ps
package audio_ser_tx_pkg;

  // Widest sample the bit picker accepts.
  localparam int MAX_WORD_W = 64;

  // Bit sent in a given slot of a half-frame. The word is MSB-first and
  // keep_w bits long; slots past keep_w (or past the sample) give 0.
  function automatic logic pick_bit(input logic [MAX_WORD_W-1:0] word,
                                    input int word_w,
                                    input int slot,
                                    input int keep_w);
    logic [MAX_WORD_W-1:0] shifted;
    if (slot >= keep_w || slot >= word_w) return 1'b0;
    shifted = word >> (word_w - 1 - slot);
    return shifted[0];
  endfunction

endpackage

// File: rtl/audio_ser_tx_edge.sv
`timescale 1ns/1ps
module audio_ser_tx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic frame_i,
  output logic fall_o,
  output logic frame_o
);
  // Stage 0..STAGES-1 synchronize; the top stage holds the previous level.
  logic [STAGES:0] bpipe;
  logic [STAGES:0] fpipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpipe <= '0;
      fpipe <= '0;
    end else begin
      bpipe <= {bpipe[STAGES-1:0], bclk_i};
      fpipe <= {fpipe[STAGES-1:0], frame_i};
    end
  end

  assign fall_o  = bpipe[STAGES] & ~bpipe[STAGES-1];
  assign frame_o = fpipe[STAGES-1];
endmodule

// File: rtl/audio_ser_tx_framer.sv
`timescale 1ns/1ps
module audio_ser_tx_framer #(
  parameter int CNT_W        = 9,
  parameter int SLOT_W       = 6,
  parameter int NARROW_FRAME = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down_i,
  input  logic              fall_i,
  input  logic              frame_lvl_i,
  input  logic              fmt_i2s_i,
  output logic              half_start_o,
  output logic              frame_start_o,
  output logic              left_side_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              narrow_o,
  output logic              seen_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX    = {CNT_W{1'b1}};
  localparam logic [SLOT_W-1:0] SLOT_MAX   = {SLOT_W{1'b1}};
  localparam logic [CNT_W-1:0]  NARROW_CNT = CNT_W'(NARROW_FRAME);

  logic              lvl_valid_q, lvl_prev_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic              narrow_q, seen_q;

  // A half-frame begins when the frame level differs from the one seen at
  // the previous bit-clock fall; the left half depends on the format.
  assign left_side_o   = frame_lvl_i ^ fmt_i2s_i;
  assign half_start_o  = fall_i & lvl_valid_q & (frame_lvl_i != lvl_prev_q);
  assign frame_start_o = half_start_o & left_side_o;

  always_comb begin
    if (half_start_o)          slot_o = '0;
    else if (slot_q == SLOT_MAX) slot_o = slot_q;
    else                       slot_o = slot_q + 1'b1;
  end

  assign narrow_o = frame_start_o ? (seen_q && cnt_q == NARROW_CNT) : narrow_q;
  assign seen_o   = seen_q | frame_start_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_valid_q <= 1'b0;
      lvl_prev_q  <= 1'b0;
      cnt_q       <= '0;
      slot_q      <= '0;
      narrow_q    <= 1'b0;
      seen_q      <= 1'b0;
    end else if (pwr_down_i) begin
      lvl_valid_q <= 1'b0;
      lvl_prev_q  <= 1'b0;
      cnt_q       <= '0;
      slot_q      <= '0;
      narrow_q    <= 1'b0;
      seen_q      <= 1'b0;
    end else if (fall_i) begin
      lvl_valid_q <= 1'b1;
      lvl_prev_q  <= frame_lvl_i;
      slot_q      <= slot_o;
      narrow_q    <= narrow_o;
      seen_q      <= seen_o;
      if (frame_start_o)         cnt_q <= CNT_W'(1);
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/audio_ser_tx_shifter.sv
`timescale 1ns/1ps
module audio_ser_tx_shifter
  import audio_ser_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16,
  parameter int SLOT_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_down_i,
  input  logic                fmt_i2s_i,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                fall_i,
  input  logic                frame_start_i,
  input  logic                left_side_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic                narrow_i,
  input  logic                seen_i,
  output logic [SAMPLE_W-1:0] act_left_o,
  output logic [SAMPLE_W-1:0] act_right_o,
  output logic                sdata_o
);
  logic [SAMPLE_W-1:0] pend_l, pend_r, src_l, src_r, cur_word;
  logic                lj_bit, delay_q, sdata_q;

  // The pending pair reaches the line directly in the frame-start slot.
  assign src_l    = frame_start_i ? pend_l : act_left_o;
  assign src_r    = frame_start_i ? pend_r : act_right_o;
  assign cur_word = left_side_i ? src_l : src_r;
  assign lj_bit   = seen_i ? pick_bit(MAX_WORD_W'(cur_word), SAMPLE_W, int'(slot_i),
                                      narrow_i ? NARROW_W : SAMPLE_W)
                           : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l      <= '0;
      pend_r      <= '0;
      act_left_o  <= '0;
      act_right_o <= '0;
    end else begin
      if (load_i) begin
        pend_l <= left_i;
        pend_r <= right_i;
      end
      if (frame_start_i) begin
        act_left_o  <= pend_l;
        act_right_o <= pend_r;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q <= 1'b0;
      sdata_q <= 1'b0;
    end else if (pwr_down_i) begin
      delay_q <= 1'b0;
      sdata_q <= 1'b0;
    end else if (fall_i) begin
      delay_q <= lj_bit;
      sdata_q <= fmt_i2s_i ? delay_q : lj_bit;
    end
  end

  assign sdata_o = sdata_q;
endmodule

// File: rtl/audio_ser_tx.sv
`timescale 1ns/1ps
module audio_ser_tx #(
  parameter int SAMPLE_W     = 24,
  parameter int NARROW_W     = 16,
  parameter int NARROW_FRAME = 32,
  parameter int SYNC_STAGES  = 2,
  parameter int CNT_W        = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                frame_i,
  input  logic                fmt_i2s_i,
  input  logic                pwr_down_i,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o
);
  localparam int SLOT_W = $clog2(SAMPLE_W) + 1;

  logic              fall_evt, frame_lvl;
  logic              half_start, frame_start, left_side, narrow_now, seen_now;
  logic [SLOT_W-1:0] slot_now;
  logic [SAMPLE_W-1:0] act_left, act_right;

  audio_ser_tx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .frame_i(frame_i),
    .fall_o(fall_evt), .frame_o(frame_lvl)
  );

  audio_ser_tx_framer #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .NARROW_FRAME(NARROW_FRAME)) u_framer (
    .clk(clk), .rst_n(rst_n), .pwr_down_i(pwr_down_i), .fall_i(fall_evt),
    .frame_lvl_i(frame_lvl), .fmt_i2s_i(fmt_i2s_i),
    .half_start_o(half_start), .frame_start_o(frame_start), .left_side_o(left_side),
    .slot_o(slot_now), .narrow_o(narrow_now), .seen_o(seen_now)
  );

  audio_ser_tx_shifter #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W), .SLOT_W(SLOT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .pwr_down_i(pwr_down_i), .fmt_i2s_i(fmt_i2s_i),
    .load_i(load_i), .left_i(left_i), .right_i(right_i), .fall_i(fall_evt),
    .frame_start_i(frame_start), .left_side_i(left_side), .slot_i(slot_now),
    .narrow_i(narrow_now), .seen_i(seen_now),
    .act_left_o(act_left), .act_right_o(act_right), .sdata_o(sdata_o)
  );
endmodule

// File: rtl/audio_ser_tx_checks.sv
`timescale 1ns/1ps
module audio_ser_tx_checks #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwr_down,
  input logic                sdata,
  input logic                fall_evt,
  input logic                half_start,
  input logic                frame_start,
  input logic [SAMPLE_W-1:0] act_left,
  input logic [SAMPLE_W-1:0] act_right
);
  // R8: the line is low the cycle after power-down is seen.
  assert_pd_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !sdata);

  // R8: no half-frame boundary is taken right after power-down.
  assert_pd_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !half_start);

  // R2: the line only moves after a detected bit-clock fall (or power-down).
  assert_move_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_evt && !pwr_down) |=> $stable(sdata));

  // R7: the transmitted pair changes only at a frame start.
  assert_pair_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_left) && $stable(act_right)));
endmodule

bind audio_ser_tx audio_ser_tx_checks #(.SAMPLE_W(SAMPLE_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down_i), .sdata(sdata_o),
  .fall_evt(fall_evt), .half_start(half_start), .frame_start(frame_start),
  .act_left(act_left), .act_right(act_right)
);

// File: tb/audio_ser_tx_test.sv
`timescale 1ns/1ps
module audio_ser_tx_test;
  localparam int PHASE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b1, frame = 1'b0, fmt = 1'b0, pd = 1'b0, load = 1'b0;
  logic [23:0] left_d = '0, right_d = '0;
  logic sdata;

  audio_ser_tx uut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .frame_i(frame), .fmt_i2s_i(fmt),
    .pwr_down_i(pd), .load_i(load), .left_i(left_d), .right_i(right_d), .sdata_o(sdata)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit expq[$];
  string tagq[$];
  bit m_delay = 1'b0;
  int m_prev_len = 0;
  bit mon_e;
  string mon_t;

  task automatic check_bit(input string tag, input logic got, input logic expd);
    checks++;
    if (got !== expd) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, expd);
    end
  endtask

  // Monitor: compares each bit in the bit-clock high phase.
  always @(posedge bclk) begin
    if (rst_n && !done) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected bit slot, got %0b expected none", sdata);
      end else begin
        mon_e = expq.pop_front();
        mon_t = tagq.pop_front();
        check_bit(mon_t, sdata, mon_e);
      end
    end
  end

  task automatic drive_slot(input bit lvl, input bit expd, input string tag);
    @(negedge clk);
    bclk = 1'b0; frame = lvl;
    expq.push_back(expd); tagq.push_back(tag);
    repeat (PHASE) @(negedge clk);
    bclk = 1'b1;
    repeat (PHASE - 1) @(negedge clk);
  endtask

  task automatic load_pair(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    left_d = l; right_d = r; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  function automatic bit left_lvl();
    return fmt ? 1'b0 : 1'b1;
  endfunction

  task automatic idle_slot(input string tag);
    bit expd;
    expd = fmt ? m_delay : 1'b0;
    m_delay = 1'b0;
    drive_slot(!left_lvl(), expd, tag);
  endtask

  // Driver: sends one frame and queues the expected stream. cut >= 0 stops
  // after that left slot (used to enter power-down mid-frame).
  task automatic run_frame(input int n, input logic [23:0] wl, input logic [23:0] wr,
                           input bit mid, input logic [23:0] nl, input logic [23:0] nr,
                           input int cut, input string req);
    int half, width;
    bit lj, expd;
    logic [23:0] w, sh;
    half  = n / 2;
    width = (m_prev_len == 32) ? 16 : 24;
    for (int side = 0; side < 2; side++) begin
      w = (side == 0) ? wl : wr;
      for (int k = 0; k < half; k++) begin
        if (side == 0 && mid && k == half / 2) load_pair(nl, nr);
        sh = w >> (23 - k);
        lj = (k < width) ? sh[0] : 1'b0;
        expd = fmt ? m_delay : lj;
        m_delay = lj;
        drive_slot(side == 0 ? left_lvl() : !left_lvl(), expd,
                   $sformatf("%s n=%0d %s slot %0d", req, n, side == 0 ? "L" : "R", k));
        if (side == 0 && k == cut) return;
      end
    end
    m_prev_len = n;
  endtask

  task automatic power_cycle(input bit new_fmt);
    @(negedge clk);
    pd = 1'b1;
    repeat (3) @(negedge clk);
    check_bit("R8 output forced low in power-down", sdata, 1'b0);
    drive_slot(1'b1, 1'b0, "R8 pd slot 0");
    drive_slot(1'b0, 1'b0, "R8 pd slot 1");
    drive_slot(1'b1, 1'b0, "R8 pd slot 2");
    fmt = new_fmt; m_delay = 1'b0; m_prev_len = 0;
    @(negedge clk);
    pd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_bit("R9 reset output low", sdata, 1'b0);

    // Left-justified framing
    load_pair(24'hA5C35A, 24'h3C96F1);
    idle_slot("R9 idle before first frame");
    run_frame(64, 24'hA5C35A, 24'h3C96F1, 1, 24'h81F00F, 24'h7E0FF3, -1, "R1 R3 R5 R7");
    run_frame(64, 24'h81F00F, 24'h7E0FF3, 1, 24'hD2B4E7, 24'h4B1D29, -1, "R1 R3 R7");
    run_frame(48, 24'hD2B4E7, 24'h4B1D29, 1, 24'hF0A5C3, 24'h96E1B7, -1, "R3 R5 48clk");
    run_frame(32, 24'hF0A5C3, 24'h96E1B7, 1, 24'hC3D2E1, 24'h1A2B3C, -1, "R5 R6 32clk");
    run_frame(32, 24'hC3D2E1, 24'h1A2B3C, 1, 24'h12345F, 24'hEDCBA7, -1, "R6 32clk");
    run_frame(64, 24'h12345F, 24'hEDCBA7, 1, 24'h6789AB, 24'h9A5F3D, -1, "R6 narrow after 32");
    run_frame(64, 24'h6789AB, 24'h9A5F3D, 1, 24'hFFEE11, 24'h55AA33, -1, "R6 wide again");
    run_frame(64, 24'hFFEE11, 24'h55AA33, 0, 24'h0, 24'h0, 1, "R3 pre-pd");

    // Switch to I2S framing inside power-down
    power_cycle(1'b1);
    load_pair(24'hB7C3D9, 24'h2E4F61);
    idle_slot("R9 idle after pd exit");
    run_frame(64, 24'hB7C3D9, 24'h2E4F61, 1, 24'h8F3C2B, 24'h71D5A9, -1, "R4 R1 R7");
    run_frame(48, 24'h8F3C2B, 24'h71D5A9, 1, 24'hC5A3E1, 24'h3B7D19, -1, "R4 R5 48clk spill");
    run_frame(32, 24'hC5A3E1, 24'h3B7D19, 1, 24'hE4D3C2, 24'h1B2C3D, -1, "R4 R6 32clk");
    run_frame(32, 24'hE4D3C2, 24'h1B2C3D, 1, 24'hA1B2C7, 24'h5D6E7F, -1, "R4 R6 32clk");
    run_frame(64, 24'hA1B2C7, 24'h5D6E7F, 1, 24'hF3E2D1, 24'h0C1D2E, -1, "R4 R6 narrow after 32");
    run_frame(32, 24'hF3E2D1, 24'h0C1D2E, 1, 24'hC8A6E4, 24'h3579BD, -1, "R4 32clk");
    run_frame(32, 24'hC8A6E4, 24'h3579BD, 0, 24'h0, 24'h0, 2, "R4 pre-pd");

    // Power-down after a 32-clock frame: next frame must be 24-bit
    power_cycle(1'b1);
    load_pair(24'h9C8B7F, 24'h6A5B4D);
    idle_slot("R9 idle after second pd exit");
    run_frame(64, 24'h9C8B7F, 24'h6A5B4D, 0, 24'h0, 24'h0, -1, "R8 wide after pd");

    repeat (4) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2: got %0d pending bits expected 0", expq.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule